// File: doc/BRIEF.md
# Synchronous FIFO with Showahead Option

A single-clock first-in first-out buffer built on an inferred register array. A word is stored on each clock edge where the write strobe is high. One entry is removed on each clock edge where the read strobe is high. The parameter `DEPTH` sets the capacity. An occupancy count and four status flags report the fill state: full, empty, nearly full and nearly empty. The two nearly flags use thresholds set by parameters.

The parameter `SHOWAHEAD` selects the read timing.

- **Classic mode (`SHOWAHEAD=0`):** the popped word reaches the registered output one cycle after the read strobe.
- **Showahead mode (`SHOWAHEAD=1`):** a registered output stage always holds the oldest entry while the FIFO is not empty. The read strobe consumes that word in the same cycle it is asserted. When a write lands in the RAM slot that the output stage is about to fetch, the output register takes the incoming word directly. It does not use the old RAM contents.

State is cleared by a synchronous clear input. An asynchronous active-low reset can also be enabled with `USE_ARST`. Overflow and underflow guards are enabled by parameter. When enabled, they drop writes while full and reads while empty.

Top module: `show_fifo`

## Requirements
- R1: A write strobe while not full stores `wr_data` at the tail. `used` rises by one at the next clock edge when no read is accepted in the same cycle.
- R2: `clr` high at a clock edge empties the FIFO: `used`=0, `empty`=1, `full`=0. With `USE_ARST=1`, driving `rst_n` low gives the same result at once, without waiting for a clock edge.
- R3: With the overflow guard on, a write while `full`=1 is dropped. This holds even if a read is requested in the same cycle. `used` does not rise, and the dropped word never appears at the output.
- R4: With the underflow guard on, a read while `empty`=1 is dropped. `used` stays 0, and in classic mode `rd_data` keeps its previous value.
- R5: `near_empty` is 1 exactly when `used` is less than or equal to `NEAR_EMPTY_TH`.
- R6: `near_full` is 1 exactly when `used` is greater than or equal to `NEAR_FULL_TH`.
- R7: In classic mode, after a clock edge that accepts a read, `rd_data` shows the popped entry. It then holds until the next accepted read.
- R8: In showahead mode, while `empty`=0, `rd_data` shows the oldest stored entry. It changes only when that entry is read.
- R9: In showahead mode, a word written while the RAM holds no entry waiting for the output register goes straight to `rd_data`. It is visible right after the write's clock edge, and `empty` falls at that same edge.
- R10: `used` equals the number of entries held. A simultaneous accepted read and write leaves `used` unchanged.
- R11: `full` is 1 exactly when `used`=`DEPTH`, and `empty` is 1 exactly when `used`=0, in both read modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, used when `USE_ARST`=1 |
| clr | input | 1 | Synchronous clear |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | W | Read data (popped word in classic mode, head entry in showahead mode) |
| full | output | 1 | FIFO holds `DEPTH` entries |
| empty | output | 1 | FIFO holds no entries |
| near_full | output | 1 | Occupancy at or above `NEAR_FULL_TH` |
| near_empty | output | 1 | Occupancy at or below `NEAR_EMPTY_TH` |
| used | output | $clog2(DEPTH+1) | Number of entries held |

## Verification
A corrupted pointer or occupancy register shows up at the ports within a few cycles. If the count drifts, `used` and the flags disagree with the scoreboard after the very next edge. If a read pointer is wrong, `rd_data` shows a word out of order on the next pop in classic mode. In showahead mode it shows up as soon as the head is refilled. A missing collision bypass causes a wrong value on `rd_data` immediately after a write to an empty showahead FIFO. Both read modes are driven with the same stimulus and compared against one queue model on every cycle, so a fault is caught on the first cycle it reaches the output.

// File: rtl/show_fifo.sv
module show_fifo #(
  parameter int W             = 8,
  parameter int DEPTH         = 8,
  parameter bit SHOWAHEAD     = 1'b0,
  parameter int NEAR_EMPTY_TH = 1,
  parameter int NEAR_FULL_TH  = DEPTH - 1,
  parameter bit OVF_GUARD     = 1'b1,
  parameter bit UNF_GUARD     = 1'b1,
  parameter bit USE_ARST      = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       full,
  output logic                       empty,
  output logic                       near_full,
  output logic                       near_empty,
  output logic [$clog2(DEPTH+1)-1:0] used
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          arst_n;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] used_w;
  logic [W-1:0]  rd_q;
  logic [W-1:0]  mem [DEPTH];

  assign arst_n = USE_ARST ? rst_n : 1'b1;
  assign wr_ok  = wr_en && !(OVF_GUARD && full);
  assign rd_ok  = rd_en && !(UNF_GUARD && empty);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr] <= wr_data;

  generate
    if (!SHOWAHEAD) begin : g_classic
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          cnt_q <= '0;
          wptr  <= '0;
          rptr  <= '0;
          rd_q  <= '0;
        end else if (clr) begin
          cnt_q <= '0;
          wptr  <= '0;
          rptr  <= '0;
          rd_q  <= '0;
        end else begin
          if (wr_ok) wptr <= bump(wptr);
          if (rd_ok) begin
            rptr <= bump(rptr);
            rd_q <= mem[rptr];
          end
          cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
        end
      end

      assign used_w = cnt_q;
    end else begin : g_ahead
      logic [CW-1:0] ram_cnt;
      logic          head_vld;
      logic          pop, load, collide;
      logic [W-1:0]  head_src;

      assign pop      = rd_ok && head_vld;
      assign load     = (!head_vld || pop) && ((ram_cnt != '0) || wr_ok);
      assign collide  = wr_ok && (wptr == rptr) && (ram_cnt == '0);
      assign head_src = collide ? wr_data : mem[rptr];

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          ram_cnt  <= '0;
          head_vld <= 1'b0;
          wptr     <= '0;
          rptr     <= '0;
          rd_q     <= '0;
        end else if (clr) begin
          ram_cnt  <= '0;
          head_vld <= 1'b0;
          wptr     <= '0;
          rptr     <= '0;
          rd_q     <= '0;
        end else begin
          if (wr_ok) wptr <= bump(wptr);
          if (load) begin
            rd_q     <= head_src;
            rptr     <= bump(rptr);
            head_vld <= 1'b1;
          end else if (pop) begin
            head_vld <= 1'b0;
          end
          ram_cnt <= ram_cnt + CW'(wr_ok) - CW'(load);
        end
      end

      assign used_w = ram_cnt + CW'(head_vld);
    end
  endgenerate

  assign used       = used_w;
  assign rd_data    = rd_q;
  assign full       = (used_w == CW'(DEPTH));
  assign empty      = (used_w == '0);
  assign near_empty = (used_w <= CW'(NEAR_EMPTY_TH));
  assign near_full  = (used_w >= CW'(NEAR_FULL_TH));
endmodule

module show_fifo_chk #(
  parameter int W         = 8,
  parameter int DEPTH     = 8,
  parameter bit SHOWAHEAD = 1'b0,
  parameter bit USE_ARST  = 1'b0,
  parameter bit OVF_GUARD = 1'b1,
  parameter bit UNF_GUARD = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [W-1:0]               rd_data,
  input logic                       full,
  input logic                       empty,
  input logic [$clog2(DEPTH+1)-1:0] used
);
  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (clr || (USE_ARST && !rst_n)) armed <= 1'b1;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    clr |=> (empty && !full && used == '0));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!clr && wr_en && !rd_en && !full) |=> (used == $past(used) + 1'b1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (OVF_GUARD && !clr && full && wr_en && !rd_en) |=> (full && $stable(used)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (UNF_GUARD && !clr && empty && rd_en && !wr_en) |=> (empty && used == '0));

  p_balanced_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!clr && wr_en && rd_en && !full && !empty) |=> $stable(used));

  p_hold_data_r7_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!clr && !rd_en && (!SHOWAHEAD || !empty)) |=> $stable(rd_data));
endmodule

bind show_fifo show_fifo_chk #(
  .W(W), .DEPTH(DEPTH), .SHOWAHEAD(SHOWAHEAD), .USE_ARST(USE_ARST),
  .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .full(full), .empty(empty), .used(used)
);

// File: tb/show_fifo_tb_top.sv
module show_fifo_tb_top;
  localparam int W = 8, DEPTH = 8, NE = 2, NF = 6;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] c_data, s_data;
  logic c_full, c_empty, c_nf, c_ne, s_full, s_empty, s_nf, s_ne;
  logic [CW-1:0] c_used, s_used;

  int tests = 0, fails = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] cls_exp = '0;

  always #10 clk = ~clk;

  show_fifo #(.W(W), .DEPTH(DEPTH), .SHOWAHEAD(1'b0), .NEAR_EMPTY_TH(NE),
              .NEAR_FULL_TH(NF), .USE_ARST(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(c_data), .full(c_full), .empty(c_empty),
    .near_full(c_nf), .near_empty(c_ne), .used(c_used));

  show_fifo #(.W(W), .DEPTH(DEPTH), .SHOWAHEAD(1'b1), .NEAR_EMPTY_TH(NE),
              .NEAR_FULL_TH(NF), .USE_ARST(1'b1)) dut_sa_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(s_data), .full(s_full), .empty(s_empty),
    .near_full(s_nf), .near_empty(s_ne), .used(s_used));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = mq.size();
    chk("R10 classic used", 32'(c_used), n);
    chk("R10 showahead used", 32'(s_used), n);
    chk("R11 classic full", 32'(c_full), 32'(n == DEPTH));
    chk("R11 classic empty", 32'(c_empty), 32'(n == 0));
    chk("R11 showahead full", 32'(s_full), 32'(n == DEPTH));
    chk("R11 showahead empty", 32'(s_empty), 32'(n == 0));
    chk("R5 near_empty", 32'(c_ne), 32'(n <= NE));
    chk("R5 near_empty sa", 32'(s_ne), 32'(n <= NE));
    chk("R6 near_full", 32'(c_nf), 32'(n >= NF));
    chk("R6 near_full sa", 32'(s_nf), 32'(n >= NF));
    chk("R7 classic rd_data", 32'(c_data), 32'(cls_exp));
    if (n > 0) chk("R8 showahead head", 32'(s_data), 32'(mq[0]));
  endtask

  task automatic step(input bit w, input logic [W-1:0] d, input bit r, input bit c);
    int n;
    wr_en = w; wr_data = d; rd_en = r; clr = c;
    @(posedge clk); #1;
    n = mq.size();
    if (c) begin
      mq.delete();
      cls_exp = '0;
    end else begin
      if (r && n > 0) cls_exp = mq.pop_front();
      if (w && n < DEPTH) mq.push_back(d);
    end
    wr_en = 0; rd_en = 0; clr = 0;
    compare_all();
  endtask

  task automatic t_reset();
    #5 rst_n = 1'b0;
    #1 chk("R2 async empty", 32'(c_empty & s_empty), 1);
    chk("R2 async used", 32'(c_used | s_used), 0);
    mq.delete(); cls_exp = '0;
    @(negedge clk) rst_n = 1'b1;
    #1 compare_all();
  endtask

  task automatic t_fill_overflow();
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0);
    chk("R1 filled", 32'(c_used), DEPTH);
    step(1, 8'hEE, 0, 0);
    chk("R3 write dropped", 32'(s_used), DEPTH);
    step(1, 8'hEF, 1, 0);
    chk("R3 write dropped with read", 32'(c_used), DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) step(0, '0, 1, 0);
    chk("R3 drained, dropped word absent", 32'(cls_exp), 32'h17);
  endtask

  task automatic t_underflow();
    logic [W-1:0] held = c_data;
    step(0, '0, 1, 0);
    step(1'b0, '0, 1'b1, 1'b0);
    chk("R4 used stays 0", 32'(c_used), 0);
    chk("R4 classic data held", 32'(c_data), 32'(held));
  endtask

  task automatic t_bypass_balanced();
    step(1, 8'hA5, 0, 0);
    chk("R9 bypass data", 32'(s_data), 32'hA5);
    chk("R9 empty fell", 32'(s_empty), 0);
    step(1, 8'h5A, 1, 0);
    chk("R9 bypass on pop", 32'(s_data), 32'h5A);
    for (int i = 0; i < 3; i++) step(1, 8'h30 + 8'(i), 0, 0);
    for (int i = 0; i < 5; i++) step(1, 8'h40 + 8'(i), 1, 0);
    chk("R10 balanced used", 32'(s_used), 4);
    step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    chk("R8 head held without read", 32'(s_data), 32'(mq[0]));
  endtask

  task automatic t_clear();
    step(1, 8'h77, 0, 0);
    step(1, 8'h00, 0, 1);
    chk("R2 sync clear", 32'(c_used | s_used), 0);
    step(1, 8'h99, 0, 0);
    chk("R1 write after clear", 32'(s_data), 32'h99);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_overflow();
    t_underflow();
    t_bypass_balanced();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule